// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block holds the host-visible control state of one bus-master DMA channel for a disk interface. Software reaches a command byte, a status byte and a byte-addressed descriptor-table base pointer through a single-cycle register port. The DMA engine gets the run flag, the transfer direction and the table base from the block. It reports end-of-table, error and drive-interrupt events back as one-cycle pulses.

The status byte holds three kinds of bit. One is set by hardware and read-only. Two are sticky event flags that software clears by writing 1. Two are plain read/write flags that software uses to record which of the two drives may use DMA. The block also drives an interrupt line. It gives a completion verdict that software samples after stopping the engine: the transfer succeeded only if the engine is idle, no error was flagged, and the drive interrupted.

The register port has no back-pressure. Every write is taken in the cycle `reg_wr` is high. Reads are combinational from `reg_addr` and never stall. The engine-side pins are plain level or pulse signals with no handshake.

Top module: `bmdma_ctrl_regs`

## Requirements
- R1: After reset, every register reads 0 and `eng_start`, `eng_to_mem`, `eng_table_ptr`, `irq_o` and `xfer_ok` are all 0.
- R2: A write to offset 0 updates the run flag from data bit 0, which appears on `eng_start` and reads back at bit 0 in the next cycle. Data bit 3 sets the direction, which appears on `eng_to_mem` and reads back at bit 3; a 1 means drive to memory. All other command bits read 0.
- R3: While the run flag is 1, a command write leaves the direction unchanged and only the run flag takes effect.
- R4: Status bit 0 (active) becomes 1 in the cycle after a command write turns the run flag from 0 to 1. It becomes 0 after an `evt_done` or `evt_err` pulse. Writing the status byte or rewriting a run flag that is already 1 leaves it unchanged.
- R5: An `evt_err` pulse sets status bit 1 and an `evt_irq` pulse sets status bit 2. A status write (offset 2) with a 1 in either position clears that flag, and a 0 leaves it. An event in the same cycle as a clearing write wins, so the flag stays 1.
- R6: Status bits 5 and 6 are read/write DMA-capable flags for drive 0 and drive 1. A status write changes only these two bits and the clear-on-1 flags.
- R7: `irq_o` is 1 exactly when status bit 2 is 1.
- R8: Offsets 4 to 7 hold the table pointer, one byte each, least significant byte at offset 4. The two lowest address bits always read 0. `eng_table_ptr` carries the stored value.
- R9: Table pointer writes are ignored while the run flag is 1.
- R10: `xfer_ok` is 1 only when the run flag is 0, active is 0, error is 0 and interrupt is 1.
- R11: Offsets 1 and 3 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` (combinational) |
| eng_start | output | 1 | Run flag to the DMA engine |
| eng_to_mem | output | 1 | Direction: 1 = drive to memory |
| eng_table_ptr | output | PTR_W | Descriptor table base address |
| evt_done | input | 1 | Engine reached the end of the table (pulse) |
| evt_err | input | 1 | Engine error (pulse) |
| evt_irq | input | 1 | Drive interrupt (pulse) |
| irq_o | output | 1 | Interrupt request, follows the interrupt flag |
| xfer_ok | output | 1 | Successful-completion verdict |

## Verification
The bench builds the block with its defaults: a 32-bit pointer with two alignment bits, so that pointer writes cover four byte lanes and byte 0 is masked. This makes the lane ordering at offsets 4 to 7 and the forced-zero low bits checkable. The bench runs a full start, interrupt, done and stop cycle, then an error-ended cycle. Along the way it probes the collision of a clearing write with set events, the direction and pointer locks while running, and the cases where a start write does not re-arm the active flag.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // register byte offsets
  localparam int OFS_CMD  = 0;
  localparam int OFS_STAT = 2;
  localparam int OFS_PTR  = 4;
  // command bit positions
  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  // status bit positions
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_CAP   = 5;
  localparam int NUM_DRV  = 2;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic wr_run,
  input  logic wr_dir,
  output logic run,
  output logic to_mem,
  output logic run_rise
);
  // start edge seen by the status block in the same cycle as the write
  assign run_rise = wr_cmd & wr_run & ~run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      to_mem <= 1'b0;
    end else if (wr_cmd) begin
      run <= wr_run;
      if (!run) to_mem <= wr_dir;
    end
  end
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stat,
  input  logic               clr_err,
  input  logic               clr_irq,
  input  logic [NUM_DRV-1:0] cap_wr,
  input  logic               run_rise,
  input  logic               evt_done,
  input  logic               evt_err,
  input  logic               evt_irq,
  output logic               active,
  output logic               err,
  output logic               irq,
  output logic [NUM_DRV-1:0] cap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (run_rise) begin
      active <= 1'b1;
    end else if (evt_done || evt_err) begin
      active <= 1'b0;
    end
  end

  // sticky flags: a set event outranks a software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (evt_err)                 err <= 1'b1;
      else if (wr_stat && clr_err) err <= 1'b0;
      if (evt_irq)                 irq <= 1'b1;
      else if (wr_stat && clr_irq) irq <= 1'b0;
    end
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n)       cap[d] <= 1'b0;
      else if (wr_stat) cap[d] <= cap_wr[d];
    end
  end
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] lane,
  input  logic [7:0]        wdata,
  output logic [PTR_W-1:0]  ptr
);
  localparam int LANES = PTR_W / 8;
  localparam logic [PTR_W-1:0] KEEP = ~((PTR_W)'((64'd1 << ALIGN_BITS) - 64'd1));

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr[8*b +: 8] <= 8'h00;
      else if (wr_en && lane == ADDR_W'(b))
        ptr[8*b +: 8] <= wdata & KEEP[8*b +: 8];
    end
  end
endmodule

// File: rtl/bmdma_ctrl_regs.sv
module bmdma_ctrl_regs
  import bmdma_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2,
  parameter int ADDR_W     = $clog2(OFS_PTR + PTR_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              eng_start,
  output logic              eng_to_mem,
  output logic [PTR_W-1:0]  eng_table_ptr,
  input  logic              evt_done,
  input  logic              evt_err,
  input  logic              evt_irq,
  output logic              irq_o,
  output logic              xfer_ok
);
  localparam int LANES = PTR_W / 8;

  logic               hit_cmd, hit_stat, hit_ptr;
  logic [ADDR_W-1:0]  ptr_lane;
  logic               run_rise;
  logic               st_active, st_err, st_irq;
  logic [NUM_DRV-1:0] st_cap;

  assign hit_cmd  = (reg_addr == ADDR_W'(OFS_CMD));
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_ptr  = (reg_addr >= ADDR_W'(OFS_PTR));
  assign ptr_lane = reg_addr - ADDR_W'(OFS_PTR);

  bmdma_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (reg_wr & hit_cmd),
    .wr_run   (reg_wdata[CMD_RUN]),
    .wr_dir   (reg_wdata[CMD_DIR]),
    .run      (eng_start),
    .to_mem   (eng_to_mem),
    .run_rise (run_rise)
  );

  bmdma_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (reg_wr & hit_stat),
    .clr_err  (reg_wdata[ST_ERR]),
    .clr_irq  (reg_wdata[ST_IRQ]),
    .cap_wr   (reg_wdata[ST_CAP +: NUM_DRV]),
    .run_rise (run_rise),
    .evt_done (evt_done),
    .evt_err  (evt_err),
    .evt_irq  (evt_irq),
    .active   (st_active),
    .err      (st_err),
    .irq      (st_irq),
    .cap      (st_cap)
  );

  bmdma_ptr_reg #(
    .PTR_W      (PTR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .ADDR_W     (ADDR_W)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr & hit_ptr & ~eng_start),
    .lane  (ptr_lane),
    .wdata (reg_wdata),
    .ptr   (eng_table_ptr)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (hit_cmd) begin
      reg_rdata[CMD_RUN] = eng_start;
      reg_rdata[CMD_DIR] = eng_to_mem;
    end else if (hit_stat) begin
      reg_rdata[ST_ACT] = st_active;
      reg_rdata[ST_ERR] = st_err;
      reg_rdata[ST_IRQ] = st_irq;
      reg_rdata[ST_CAP +: NUM_DRV] = st_cap;
    end else if (hit_ptr) begin
      for (int b = 0; b < LANES; b++)
        if (ptr_lane == ADDR_W'(b)) reg_rdata = eng_table_ptr[8*b +: 8];
    end
  end

  assign irq_o   = st_irq;
  assign xfer_ok = ~eng_start & ~st_active & ~st_err & st_irq;
endmodule

// File: rtl/bmdma_ctrl_regs_chk.sv
module bmdma_ctrl_regs_chk #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              eng_start,
  input logic [PTR_W-1:0]  eng_table_ptr,
  input logic              evt_done,
  input logic              evt_err,
  input logic              evt_irq,
  input logic              irq_o,
  input logic              xfer_ok,
  input logic              st_active,
  input logic              st_err
);
  logic cmd_wr, rise_wr;
  assign cmd_wr  = reg_wr && reg_addr == '0;
  assign rise_wr = cmd_wr && reg_wdata[0] && !eng_start;

  a_r2_run_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> eng_start == $past(reg_wdata[0]));

  a_r9_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> eng_table_ptr == $past(eng_table_ptr));

  a_r4_active_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_wr |=> st_active);

  a_r4_active_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_done || evt_err) && !rise_wr) |=> !st_active);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> st_err);

  a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |=> irq_o);

  a_r10_error_blocks_ok: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> !xfer_ok);
endmodule

bind bmdma_ctrl_regs bmdma_ctrl_regs_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .eng_start     (eng_start),
  .eng_table_ptr (eng_table_ptr),
  .evt_done      (evt_done),
  .evt_err       (evt_err),
  .evt_irq       (evt_irq),
  .irq_o         (irq_o),
  .xfer_ok       (xfer_ok),
  .st_active     (st_active),
  .st_err        (st_err)
);

// File: tb/bmdma_ctrl_regs_test.sv
`timescale 1ns/1ps
module bmdma_ctrl_regs_test;
  localparam int PTR_W  = 32;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0]        reg_wdata = 8'h00;
  logic [7:0]        reg_rdata;
  logic              eng_start, eng_to_mem, irq_o, xfer_ok;
  logic [PTR_W-1:0]  eng_table_ptr;
  logic              evt_done = 1'b0, evt_err = 1'b0, evt_irq = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // probe selectors
  localparam int P_RD = 0, P_RUN = 1, P_DIR = 2, P_IRQ = 3, P_OK = 4, P_PTR = 5;

  int           sel_q[$];
  logic [31:0]  exp_q[$];
  string        tag_q[$];
  event         smp;

  always #2 clk = ~clk;

  bmdma_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_to_mem(eng_to_mem), .eng_table_ptr(eng_table_ptr),
    .evt_done(evt_done), .evt_err(evt_err), .evt_irq(evt_irq),
    .irq_o(irq_o), .xfer_ok(xfer_ok)
  );

  // monitor: pops the expected item and compares it with the probed port
  always @(smp) begin
    int          s;
    logic [31:0] e, a;
    string       t;
    s = sel_q.pop_front();
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    case (s)
      P_RD:    a = {24'h0, reg_rdata};
      P_RUN:   a = {31'h0, eng_start};
      P_DIR:   a = {31'h0, eng_to_mem};
      P_IRQ:   a = {31'h0, irq_o};
      P_OK:    a = {31'h0, xfer_ok};
      default: a = eng_table_ptr;
    endcase
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s probe=%0d actual=%h expected=%h", t, s, a, e);
    end
  end

  // driver side: push expectation, then trigger the monitor
  task automatic expect_val(input int s, input logic [ADDR_W-1:0] a,
                            input logic [31:0] e, input string t);
    reg_addr = a;
    sel_q.push_back(s);
    exp_q.push_back(e);
    tag_q.push_back(t);
    #0.5;
    -> smp;
    #0.5;
  endtask

  task automatic cycle(input logic w, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic dn, input logic er, input logic iq);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    evt_done = dn; evt_err = er; evt_irq = iq;
    @(negedge clk);
    reg_wr = 1'b0; evt_done = 1'b0; evt_err = 1'b0; evt_irq = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_val(P_RD, 3'd0, 32'h00, "R1 cmd");
    expect_val(P_RD, 3'd2, 32'h00, "R1 status");
    expect_val(P_PTR, 3'd0, 32'h0, "R1 ptr");
    expect_val(P_RUN, 3'd0, 32'h0, "R1 run");
    expect_val(P_IRQ, 3'd0, 32'h0, "R1 irq");
    expect_val(P_OK, 3'd0, 32'h0, "R1 ok");

    // R11 unused offsets
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hFF);
    expect_val(P_RD, 3'd1, 32'h00, "R11 ofs1");
    expect_val(P_RD, 3'd3, 32'h00, "R11 ofs3");
    expect_val(P_RD, 3'd0, 32'h00, "R11 cmd untouched");
    expect_val(P_RD, 3'd2, 32'h00, "R11 status untouched");

    // R8 pointer lanes, low bits masked
    wr(3'd4, 8'h13); wr(3'd5, 8'h22); wr(3'd6, 8'h33); wr(3'd7, 8'h44);
    expect_val(P_PTR, 3'd0, 32'h44332210, "R8 ptr value");
    expect_val(P_RD, 3'd4, 32'h10, "R8 lane0 read");
    expect_val(P_RD, 3'd7, 32'h44, "R8 lane3 read");

    // R2 direction then run
    wr(3'd0, 8'hF8);
    expect_val(P_RD, 3'd0, 32'h08, "R2 dir only");
    expect_val(P_DIR, 3'd0, 32'h1, "R2 to_mem");
    expect_val(P_RUN, 3'd0, 32'h0, "R2 not running");
    wr(3'd0, 8'h09);
    expect_val(P_RUN, 3'd0, 32'h1, "R2 run");
    expect_val(P_RD, 3'd0, 32'h09, "R2 cmd read");
    expect_val(P_RD, 3'd2, 32'h01, "R4 active on start");

    // R9 pointer locked while running
    wr(3'd4, 8'hFF);
    expect_val(P_PTR, 3'd0, 32'h44332210, "R9 ptr locked");

    // R3 direction locked while running
    wr(3'd0, 8'h01);
    expect_val(P_RD, 3'd0, 32'h09, "R3 dir locked");

    // R6 capable flags, other status bits kept
    wr(3'd2, 8'h60);
    expect_val(P_RD, 3'd2, 32'h61, "R6 both caps");
    wr(3'd2, 8'h20);
    expect_val(P_RD, 3'd2, 32'h21, "R6 cap0 only");

    // R5 / R7 interrupt event
    cycle(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    expect_val(P_RD, 3'd2, 32'h25, "R5 irq set");
    expect_val(P_IRQ, 3'd0, 32'h1, "R7 irq out");
    expect_val(P_OK, 3'd0, 32'h0, "R10 not ok while running");

    // R4 done clears active
    cycle(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    expect_val(P_RD, 3'd2, 32'h24, "R4 done clears active");
    expect_val(P_OK, 3'd0, 32'h0, "R10 run still set");

    // R10 stop -> success
    wr(3'd0, 8'h08);
    expect_val(P_RUN, 3'd0, 32'h0, "R2 stop");
    expect_val(P_OK, 3'd0, 32'h1, "R10 success");

    // R4 status write does not touch active; R5 write 0 keeps irq
    wr(3'd2, 8'h21);
    expect_val(P_RD, 3'd2, 32'h24, "R4 active not writable");

    // R5 clear irq with write 1
    wr(3'd2, 8'h04);
    expect_val(P_RD, 3'd2, 32'h00, "R5 irq cleared");
    expect_val(P_IRQ, 3'd0, 32'h0, "R7 irq low");
    expect_val(P_OK, 3'd0, 32'h0, "R10 no irq");

    // R5 set beats clear in the same cycle
    cycle(1'b1, 3'd2, 8'h06, 1'b0, 1'b1, 1'b1);
    expect_val(P_RD, 3'd2, 32'h06, "R5 event wins");
    expect_val(P_OK, 3'd0, 32'h0, "R10 error blocks ok");
    wr(3'd2, 8'h06);
    expect_val(P_RD, 3'd2, 32'h00, "R5 both cleared");

    // R4 error clears active; direction free again when stopped
    wr(3'd0, 8'h01);
    expect_val(P_RD, 3'd2, 32'h01, "R4 active rearmed");
    expect_val(P_DIR, 3'd0, 32'h0, "R3 dir writable when stopped");
    cycle(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    expect_val(P_RD, 3'd2, 32'h02, "R4 error clears active");

    // R4 rewriting run=1 does not rearm active
    wr(3'd0, 8'h01);
    expect_val(P_RD, 3'd2, 32'h02, "R4 no rearm without edge");

    // R8/R9 pointer writable after stop
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hFF);
    expect_val(P_PTR, 3'd0, 32'h443322FC, "R8 lane0 masked");

    if (sel_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 scoreboard leftover actual=%0d expected=0", sel_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule